// File: doc/BRIEF.md
# Paged Register Bank with Write Lock

This block is a byte-wide register file placed behind the generic read/write bus of a serial host interface. Reads that fall inside a fixed sixteen-byte window (addresses C0h to CFh) are redirected. The window's upper address nibble is swapped for a programmable region number, so any sixteen-byte page of the bank can be viewed through the window. Writes are never redirected. A region register holds the requested region number and also shows the region that is actually applied. The host reads it back to confirm which page the window is showing.

A control register holds a one-way end-of-initialisation lock. Once the lock is set, the bank rejects every write except a write to the two reset-command bits. From then on the region used by the window is frozen. A protocol-selection register at 16h chooses the serial protocol. A write that keeps the protocol now in use enabled takes effect at once. A write that would turn off that protocol is only stored, and it takes effect at the next device reset. Two source-identification bytes are plain storage that either protocol may use.

The bank has two resets. Power-on reset (`porN`) clears everything, including the protocol register. Device reset (`devRst`) clears everything except the protocol register, and it copies the stored protocol code into the effective selection.

Top module: `pagedRegBank`

## Requirements
- R1: After power-on reset, every register reads 00h and `effProto` is 000.
- R2: A write to an ordinary address stores the byte. A read strobe at address A loads the byte at A into `busRdata` at the next clock edge, and `busRdata` holds that value until the next read.
- R3: A read at C0h–CFh returns the byte at {regionActive, low address nibble}. Reads at any other address, and all writes, use the literal address. For example, with region Ah, reading C2h returns the byte stored at A2h.
- R4: The region register at 11h takes the requested region from write bits 3:0. It reads back as {active region in bits 7:4, requested region in bits 3:0}. The active region follows the requested one after one clock.
- R5: The control register at 10h holds the lock in bit 0 and the reset-command field in bits 7:6, and reads 0 in bits 5:1. Writing 1 to bit 0 sets the lock. Writing 0 to bit 0 never clears it.
- R6: While the lock is set, writes to every address are ignored, except that bits 7:6 of 10h still update.
- R7: While the lock is set, the region register cannot change. Window reads keep using the region that was active when the lock was set.
- R8: The protocol register at 16h stores all 8 written bits and reads them back. In code bits 2:0, SPI is enabled by codes 000, 001, 010 and 100, and I2C by codes 000, 001, 110 and 111. Codes 011 and 101 enable neither. `actProto` = 0 means SPI is in use, and 1 means I2C.
- R9: A write to 16h whose code keeps the in-use protocol enabled updates `effProto` at the write's clock edge.
- R10: A write to 16h whose code disables the in-use protocol leaves `effProto` unchanged.
- R11: Device reset clears the lock, the reset-command field, the region register, the source-ID registers, the general storage and `busRdata`. It loads `effProto` from bits 2:0 of 16h and keeps the value of 16h.
- R12: The source-ID registers at 1Ah and 1Bh are read/write whatever the value of `actProto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| devRst | input | 1 | Synchronous device reset, active high |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| actProto | input | 1 | Protocol now in use (0 SPI, 1 I2C) |
| busRdata | output | 8 | Registered read data |
| effProto | output | 3 | Effective protocol selection |

## Verification
Most faults in the internal state show up as a wrong byte on the read port one cycle after a read strobe. A lock that drops, a region that moves after the lock, or a wrongly substituted page nibble appears on the very next readback of 10h, 11h or a window address. A broken deferral rule for the protocol shows on `effProto` in the cycle right after the write, and a lost pending code shows right after the next device reset. The bench therefore reads back after every class of write and compares `effProto` after every write to 16h and every device reset.

// File: rtl/pagedBankPkg.sv
package pagedBankPkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int OFF_W   = 4;
  localparam int PAGE_W  = ADDR_W - OFF_W;
  localparam int SRC_N   = 2;
  localparam int PROTO_W = 3;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int RST_W   = 2;

  localparam logic [ADDR_W-1:0] CTL_ADDR    = 8'h10;
  localparam logic [ADDR_W-1:0] REGION_ADDR = 8'h11;
  localparam logic [ADDR_W-1:0] PROTO_ADDR  = 8'h16;
  localparam logic [ADDR_W-1:0] SRC_BASE    = 8'h1A;
  localparam logic [PAGE_W-1:0] WIN_PAGE    = 4'hC;

  typedef struct packed {
    logic              wrCtl;
    logic              wrRegion;
    logic              wrProto;
    logic [SRC_N-1:0]  wrSrc;
    logic              wrArray;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } bankStrobeT;

  function automatic logic spiOn(input logic [PROTO_W-1:0] code);
    case (code)
      3'b000, 3'b001, 3'b010, 3'b100: spiOn = 1'b1;
      default:                        spiOn = 1'b0;
    endcase
  endfunction

  function automatic logic i2cOn(input logic [PROTO_W-1:0] code);
    case (code)
      3'b000, 3'b001, 3'b110, 3'b111: i2cOn = 1'b1;
      default:                        i2cOn = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pagedBankCtrl.sv
module pagedBankCtrl
  import pagedBankPkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              devRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wdLock,
  input  logic [RST_W-1:0]  wdRst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PAGE_W-1:0] regionActive,
  output bankStrobeT        st,
  output logic              lockQ,
  output logic [RST_W-1:0]  rstBitsQ
);
  logic wrEn;
  logic hitCtl, hitRegion, hitProto, hitSrcAny;
  logic [SRC_N-1:0] hitSrc;

  assign wrEn      = busWr && !devRst;
  assign hitCtl    = (busAddr == CTL_ADDR);
  assign hitRegion = (busAddr == REGION_ADDR);
  assign hitProto  = (busAddr == PROTO_ADDR);

  for (genvar i = 0; i < SRC_N; i++) begin : gSrcHit
    assign hitSrc[i] = (busAddr == ADDR_W'(SRC_BASE + i));
  end
  assign hitSrcAny = |hitSrc;

  always_comb begin
    st          = '0;
    st.wrCtl    = wrEn && hitCtl;
    st.wrRegion = wrEn && !lockQ && hitRegion;
    st.wrProto  = wrEn && !lockQ && hitProto;
    st.wrSrc    = (wrEn && !lockQ) ? hitSrc : '0;
    st.wrArray  = wrEn && !lockQ && !(hitCtl || hitRegion || hitProto || hitSrcAny);
    st.rdEn     = busRd;
    // Window reads substitute the applied region for the page nibble
    if (busAddr[ADDR_W-1:OFF_W] == WIN_PAGE)
      st.rdAddr = {regionActive, busAddr[OFF_W-1:0]};
    else
      st.rdAddr = busAddr;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      lockQ    <= 1'b0;
      rstBitsQ <= '0;
    end else if (devRst) begin
      lockQ    <= 1'b0;
      rstBitsQ <= '0;
    end else if (st.wrCtl) begin
      rstBitsQ <= wdRst;
      if (wdLock) lockQ <= 1'b1;
    end
  end

  // R5
  lock_one_way_chk: assert property (@(posedge clk) disable iff (!porN)
    (lockQ && !devRst) |=> lockQ);

  // R6
  rst_field_exempt_chk: assert property (@(posedge clk) disable iff (!porN)
    (busWr && lockQ && hitCtl && !devRst) |=> (rstBitsQ == $past(wdRst)));
endmodule

// File: rtl/pagedBankData.sv
module pagedBankData
  import pagedBankPkg::*;
(
  input  logic               clk,
  input  logic               porN,
  input  logic               devRst,
  input  bankStrobeT         st,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               actProto,
  input  logic               lockQ,
  input  logic [RST_W-1:0]   rstBitsQ,
  output logic [PAGE_W-1:0]  regionActive,
  output logic [DATA_W-1:0]  rdDataQ,
  output logic [PROTO_W-1:0] effProtoQ
);
  logic [DATA_W-1:0]  mem [DEPTH];
  logic [DATA_W-1:0]  srcId [SRC_N];
  logic [PAGE_W-1:0]  regionLoad;
  logic [DATA_W-1:0]  protoReg;
  logic [DATA_W-1:0]  rdMux;
  logic [PROTO_W-1:0] newCode;
  logic               keepsActive;

  assign newCode     = busWdata[PROTO_W-1:0];
  assign keepsActive = actProto ? i2cOn(newCode) : spiOn(newCode);

  // General storage
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (devRst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (st.wrArray) begin
      mem[busAddr] <= busWdata;
    end
  end

  for (genvar i = 0; i < SRC_N; i++) begin : gSrc
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)            srcId[i] <= '0;
      else if (devRst)      srcId[i] <= '0;
      else if (st.wrSrc[i]) srcId[i] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      regionLoad   <= '0;
      regionActive <= '0;
    end else if (devRst) begin
      regionLoad   <= '0;
      regionActive <= '0;
    end else begin
      if (st.wrRegion) regionLoad <= busWdata[PAGE_W-1:0];
      regionActive <= regionLoad;
    end
  end

  // Stored selection survives device reset; effective copy is deferred
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      protoReg  <= '0;
      effProtoQ <= '0;
    end else if (devRst) begin
      effProtoQ <= protoReg[PROTO_W-1:0];
    end else if (st.wrProto) begin
      protoReg <= busWdata;
      if (keepsActive) effProtoQ <= newCode;
    end
  end

  always_comb begin
    rdMux = mem[st.rdAddr];
    if (st.rdAddr == CTL_ADDR)
      rdMux = {rstBitsQ, {(DATA_W-RST_W-1){1'b0}}, lockQ};
    if (st.rdAddr == REGION_ADDR)
      rdMux = {regionActive, regionLoad};
    if (st.rdAddr == PROTO_ADDR)
      rdMux = protoReg;
    for (int i = 0; i < SRC_N; i++)
      if (st.rdAddr == ADDR_W'(SRC_BASE + i)) rdMux = srcId[i];
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)        rdDataQ <= '0;
    else if (devRst)  rdDataQ <= '0;
    else if (st.rdEn) rdDataQ <= rdMux;
  end

  // R7
  region_frozen_chk: assert property (@(posedge clk) disable iff (!porN)
    (lockQ && !devRst) |=> $stable(regionActive));

  // R6
  src_locked_chk: assert property (@(posedge clk) disable iff (!porN)
    (lockQ && !devRst) |=> $stable(srcId[0]));

  // R9
  proto_now_chk: assert property (@(posedge clk) disable iff (!porN)
    (st.wrProto && keepsActive) |=> (effProtoQ == $past(newCode)));

  // R10
  proto_defer_chk: assert property (@(posedge clk) disable iff (!porN)
    (st.wrProto && !keepsActive) |=> $stable(effProtoQ));

  // R11
  proto_load_chk: assert property (@(posedge clk) disable iff (!porN)
    devRst |=> (effProtoQ == $past(protoReg[PROTO_W-1:0])));
endmodule

// File: rtl/pagedRegBank.sv
module pagedRegBank
  import pagedBankPkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        devRst,
  input  logic [7:0]  busAddr,
  input  logic [7:0]  busWdata,
  input  logic        busWr,
  input  logic        busRd,
  input  logic        actProto,
  output logic [7:0]  busRdata,
  output logic [2:0]  effProto
);
  bankStrobeT        st;
  logic              lockQ;
  logic [RST_W-1:0]  rstBitsQ;
  logic [PAGE_W-1:0] regionActive;

  pagedBankCtrl uCtrl (
    .clk          (clk),
    .porN         (porN),
    .devRst       (devRst),
    .busAddr      (busAddr),
    .wdLock       (busWdata[0]),
    .wdRst        (busWdata[DATA_W-1 -: RST_W]),
    .busWr        (busWr),
    .busRd        (busRd),
    .regionActive (regionActive),
    .st           (st),
    .lockQ        (lockQ),
    .rstBitsQ     (rstBitsQ)
  );

  pagedBankData uData (
    .clk          (clk),
    .porN         (porN),
    .devRst       (devRst),
    .st           (st),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .actProto     (actProto),
    .lockQ        (lockQ),
    .rstBitsQ     (rstBitsQ),
    .regionActive (regionActive),
    .rdDataQ      (busRdata),
    .effProtoQ    (effProto)
  );
endmodule

// File: tb/pagedRegBank_test.sv
`timescale 1ns/1ps
module pagedRegBank_test;
  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       devRst = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic       actProto = 1'b0;
  logic [7:0] busRdata;
  logic [2:0] effProto;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  pagedRegBank uut (
    .clk(clk), .porN(porN), .devRst(devRst), .busAddr(busAddr),
    .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .actProto(actProto), .busRdata(busRdata), .effProto(effProto)
  );

  typedef struct packed {
    logic       isWr;
    logic [7:0] addr;
    logic [7:0] data;
    logic [3:0] req;
  } vecT;

  localparam int NVEC = 17;
  localparam vecT VEC [NVEC] = '{
    '{1'b1, 8'h05, 8'h33, 4'd2},   // R2 plain write
    '{1'b1, 8'hA2, 8'h5C, 4'd3},   // R3 target byte
    '{1'b1, 8'hC2, 8'h77, 4'd3},   // R3 write inside window is literal
    '{1'b1, 8'h11, 8'h0A, 4'd4},   // R4 region A
    '{1'b0, 8'h05, 8'h33, 4'd2},   // R2
    '{1'b0, 8'hC2, 8'h5C, 4'd3},   // R3 C2 -> A2
    '{1'b0, 8'h11, 8'hAA, 4'd4},   // R4
    '{1'b1, 8'h1A, 8'h12, 4'd12},  // R12
    '{1'b0, 8'h1A, 8'h12, 4'd12},  // R12
    '{1'b1, 8'h1B, 8'h34, 4'd12},  // R12
    '{1'b0, 8'h1B, 8'h34, 4'd12},  // R12
    '{1'b1, 8'h11, 8'h0C, 4'd4},   // R4 region C
    '{1'b0, 8'h1A, 8'h12, 4'd12},  // R12
    '{1'b0, 8'hC2, 8'h77, 4'd3},   // R3 region C reads C2 itself
    '{1'b0, 8'h11, 8'hCC, 4'd4},   // R4
    '{1'b0, 8'hD2, 8'h00, 4'd3},   // R3 outside window, unwritten
    '{1'b1, 8'h16, 8'hF9, 4'd8}    // R8 full byte stored
  };

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic pulseDevRst();
    @(negedge clk);
    devRst = 1'b1;
    @(negedge clk);
    devRst = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic readCheck(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    doRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic protoCheck(input string tag, input logic [2:0] exp);
    check(tag, {5'b0, effProto}, {5'b0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    porN = 1'b1;

    // R1 reset state
    protoCheck("R1 effProto", 3'b000);
    readCheck("R1 ctl", 8'h10, 8'h00);
    readCheck("R1 region", 8'h11, 8'h00);
    readCheck("R1 proto", 8'h16, 8'h00);
    readCheck("R1 src", 8'h1A, 8'h00);
    readCheck("R1 window", 8'hC0, 8'h00);

    // Vector table walk (SPI in use)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) begin
        doWrite(VEC[i].addr, VEC[i].data);
      end else begin
        doRead(VEC[i].addr, d);
        checks++;
        if (d !== VEC[i].data) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %02h expected %02h",
                   VEC[i].req, i, d, VEC[i].data);
        end
      end
    end
    readCheck("R8 readback", 8'h16, 8'hF9);
    protoCheck("R9 code 001 keeps SPI", 3'b001);

    // R9 / R10 with SPI in use
    doWrite(8'h16, 8'h02);
    protoCheck("R9 code 010", 3'b010);
    doWrite(8'h16, 8'h06);
    protoCheck("R10 I2C-only deferred", 3'b010);
    readCheck("R10 stored", 8'h16, 8'h06);

    // R11 device reset
    pulseDevRst();
    protoCheck("R11 pending adopted", 3'b110);
    readCheck("R11 proto kept", 8'h16, 8'h06);
    readCheck("R11 storage cleared", 8'h05, 8'h00);
    readCheck("R11 region cleared", 8'h11, 8'h00);
    readCheck("R11 src cleared", 8'h1A, 8'h00);

    // I2C in use
    actProto = 1'b1;
    doWrite(8'h1B, 8'h55);
    readCheck("R12 src under I2C", 8'h1B, 8'h55);
    doWrite(8'h16, 8'h07);
    protoCheck("R9 code 111 keeps I2C", 3'b111);
    doWrite(8'h16, 8'h03);
    protoCheck("R10 reserved deferred", 3'b111);
    readCheck("R8 reserved stored", 8'h16, 8'h03);
    pulseDevRst();
    protoCheck("R11 reserved adopted", 3'b011);
    doWrite(8'h1B, 8'h55);
    doWrite(8'h16, 8'h00);
    protoCheck("R9 code 000 keeps I2C", 3'b000);

    // Lock sequence
    doWrite(8'h11, 8'h05);
    doWrite(8'h52, 8'h9A);
    doWrite(8'h10, 8'h01);
    readCheck("R5 lock set", 8'h10, 8'h01);
    doWrite(8'h10, 8'hC0);
    readCheck("R6 reset field exempt", 8'h10, 8'hC1);
    doWrite(8'h10, 8'h00);
    readCheck("R5 lock one-way", 8'h10, 8'h01);
    doWrite(8'h11, 8'h0A);
    readCheck("R7 region frozen", 8'h11, 8'h55);
    readCheck("R7 window uses frozen region", 8'hC2, 8'h9A);
    doWrite(8'h1B, 8'h77);
    readCheck("R6 src locked", 8'h1B, 8'h55);
    doWrite(8'h16, 8'h07);
    protoCheck("R6 proto locked eff", 3'b000);
    readCheck("R6 proto locked reg", 8'h16, 8'h00);
    doWrite(8'h52, 8'h00);
    readCheck("R6 storage locked", 8'h52, 8'h9A);

    // R11 lock released by device reset
    pulseDevRst();
    readCheck("R11 ctl cleared", 8'h10, 8'h00);
    doWrite(8'h1B, 8'h11);
    readCheck("R11 writes reopened", 8'h1B, 8'h11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule